// File: doc/BRIEF.md
# Profile-Driven Waveform Address Ramp

This block generates the read address for a waveform memory. Software stores up to eight playback profiles through a one-cycle write port. Each profile holds a first address, a last address, a step period and a return-to-first flag. Three select pins choose the active profile. An update strobe, or any change in the value on the select pins, starts a one-shot ramp. The ramp loads the chosen profile's first address and then adds one to the address each time a step period ends. When the address reaches the last address, the block raises a completion flag and stops.

After completion, the address either stays on the last address or goes back to the first address one step period later. The return-to-first flag of the profile picks which of the two happens. A new trigger during a ramp abandons that ramp at once and starts the new one. If only one or two of the select pins are toggled, the block switches between two or four profiles.

The controller has four states. `ST_IDLE` is the state out of reset, before any trigger. `ST_RAMP` steps the address. `ST_RETURN` waits one step period and then jumps back to the first address. `ST_HOLD` is the stopped state. A trigger in any state moves the controller to `ST_RAMP`. In `ST_RAMP`, a step tick on the final step moves it to `ST_HOLD` when the return flag is clear and to `ST_RETURN` when it is set. In `ST_RETURN`, a tick moves it to `ST_HOLD`.

Top module: `ramp_addr_seq`

## Requirements
- R1: After reset, `ram_addr` is 0 and `sweep_over` is 0 until the first trigger.
- R2: A cycle with `io_update` high is a trigger. After that clock edge, `ram_addr` equals the first address of profile `prof_sel` and `sweep_over` is 0.
- R3: During a ramp, `ram_addr` increases by exactly 1 once every P clock cycles, where P is the profile's rate field. The address after k steps is visible k·P cycles after the trigger edge.
- R4: A rate field of 0 behaves exactly like a rate of 1, so the address steps every cycle.
- R5: `sweep_over` becomes 1 on the same edge on which `ram_addr` becomes the last address. From then on the address no longer increases, and the flag stays 1 until the next trigger.
- R6: When the profile's return flag is 0, `ram_addr` stays at the last address after completion.
- R7: When the return flag is 1, `ram_addr` goes back to the first address one step period after reaching the last address, and then stays there.
- R8: When the first address equals the last address, `sweep_over` rises one step period after the trigger.
- R9: A value on `prof_sel` that differs from its value in the previous cycle is a trigger, just like `io_update`. It aborts any ramp in progress.
- R10: A write with `wr_en` high stores the profile fields into slot `wr_idx`. A ramp already running keeps the values it loaded at its trigger. The new values take effect at the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prof_sel | input | SEL_W (3) | Active profile index |
| io_update | input | 1 | Trigger strobe, one cycle |
| wr_en | input | 1 | Profile write enable |
| wr_idx | input | SEL_W (3) | Profile slot to write |
| wr_start | input | ADDR_W (10) | First address to store |
| wr_end | input | ADDR_W (10) | Last address to store |
| wr_rate | input | RATE_W (16) | Step period in cycles (0 is treated as 1) |
| wr_nodwell | input | 1 | Return-to-first flag to store |
| ram_addr | output | ADDR_W (10) | Waveform memory address |
| sweep_over | output | 1 | Ramp completion flag |

## Verification
The hardest case to reach from the ports is a trigger that arrives while a ramp is still running and lands next to other events. One such event is a rewrite of the active slot, which must not disturb the running ramp. Another is a step tick that would otherwise set the completion flag. The stimulus reaches these cases in two ways. Directed sequences switch profiles mid-ramp and rewrite the playing slot. Seeded random rounds then mix writes, pin changes and strobes at random gaps against short ramps. Many triggers therefore fall near completion or near the return step.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RAMP,
        ST_RETURN,
        ST_HOLD
    } rseq_state_e;
endpackage

// File: rtl/rseq_profile_bank.sv
module rseq_profile_bank #(
    parameter int NPROF  = 8,
    parameter int ADDR_W = 10,
    parameter int RATE_W = 16,
    localparam int SEL_W = $clog2(NPROF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic [ADDR_W-1:0] wr_end,
    input  logic [RATE_W-1:0] wr_rate,
    input  logic              wr_nodwell,
    input  logic [SEL_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_start,
    output logic [ADDR_W-1:0] rd_end,
    output logic [RATE_W-1:0] rd_rate,
    output logic              rd_nodwell
);
    logic [ADDR_W-1:0] start_mem [NPROF];
    logic [ADDR_W-1:0] end_mem   [NPROF];
    logic [RATE_W-1:0] rate_mem  [NPROF];
    logic              nd_mem    [NPROF];

    for (genvar g = 0; g < NPROF; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_mem[g] <= '0;
                end_mem[g]   <= '0;
                rate_mem[g]  <= '0;
                nd_mem[g]    <= 1'b0;
            end else if (wr_en && (wr_idx == SEL_W'(g))) begin
                start_mem[g] <= wr_start;
                end_mem[g]   <= wr_end;
                rate_mem[g]  <= wr_rate;
                nd_mem[g]    <= wr_nodwell;
            end
        end
    end

    assign rd_start   = start_mem[rd_idx];
    assign rd_end     = end_mem[rd_idx];
    assign rd_rate    = rate_mem[rd_idx];
    assign rd_nodwell = nd_mem[rd_idx];
endmodule

// File: rtl/rseq_trigger.sv
module rseq_trigger #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] prof_sel,
    input  logic             io_update,
    output logic             trig
);
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= prof_sel;
    end

    assign trig = io_update || (prof_sel != sel_q);
endmodule

// File: rtl/rseq_step_timer.sv
module rseq_step_timer #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] last_cnt;

    assign last_cnt = (rate == '0) ? '0 : rate - 1'b1;
    assign tick     = !restart && (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (!rst_n || restart)    cnt_q <= '0;
        else if (cnt_q == last_cnt) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ramp_addr_seq.sv
module ramp_addr_seq
    import rseq_pkg::*;
#(
    parameter int NPROF  = 8,
    parameter int ADDR_W = 10,
    parameter int RATE_W = 16,
    localparam int SEL_W = $clog2(NPROF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  prof_sel,
    input  logic              io_update,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic [ADDR_W-1:0] wr_end,
    input  logic [RATE_W-1:0] wr_rate,
    input  logic              wr_nodwell,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              sweep_over
);
    logic              trig;
    logic              tick;
    logic [ADDR_W-1:0] rd_start, rd_end;
    logic [RATE_W-1:0] rd_rate;
    logic              rd_nodwell;
    logic [ADDR_W-1:0] start_q, end_q;
    logic [RATE_W-1:0] rate_q;
    logic              nodwell_q;
    logic              at_end, last_step;
    rseq_state_e       state_q, state_d;

    rseq_profile_bank #(.NPROF(NPROF), .ADDR_W(ADDR_W), .RATE_W(RATE_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_start(wr_start), .wr_end(wr_end),
        .wr_rate(wr_rate), .wr_nodwell(wr_nodwell),
        .rd_idx(prof_sel), .rd_start(rd_start), .rd_end(rd_end),
        .rd_rate(rd_rate), .rd_nodwell(rd_nodwell)
    );

    rseq_trigger #(.SEL_W(SEL_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel),
        .io_update(io_update), .trig(trig)
    );

    rseq_step_timer #(.RATE_W(RATE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(trig), .rate(rate_q), .tick(tick)
    );

    assign at_end    = (ram_addr == end_q);
    assign last_step = at_end || (ADDR_W'(ram_addr + 1'b1) == end_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (trig) begin
            state_d = ST_RAMP;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_RAMP:   if (tick && last_step)
                               state_d = nodwell_q ? ST_RETURN : ST_HOLD;
                ST_RETURN: if (tick) state_d = ST_HOLD;
                ST_HOLD:   state_d = ST_HOLD;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and loaded profile
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr   <= '0;
            sweep_over <= 1'b0;
            start_q    <= '0;
            end_q      <= '0;
            rate_q     <= '0;
            nodwell_q  <= 1'b0;
        end else if (trig) begin
            ram_addr   <= rd_start;
            sweep_over <= 1'b0;
            start_q    <= rd_start;
            end_q      <= rd_end;
            rate_q     <= rd_rate;
            nodwell_q  <= rd_nodwell;
        end else begin
            unique case (state_q)
                ST_RAMP: if (tick) begin
                    if (!at_end)   ram_addr   <= ram_addr + 1'b1;
                    if (last_step) sweep_over <= 1'b1;
                end
                ST_RETURN: if (tick) ram_addr <= start_q;
                ST_IDLE, ST_HOLD: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rseq_checker.sv
module rseq_checker #(
    parameter int ADDR_W = 10,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  prof_sel,
    input logic              trig,
    input logic              sweep_over,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              nodwell_q,
    input logic [ADDR_W-1:0] end_q
);
    AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !sweep_over); // R2
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !sweep_over) |=>
            (ram_addr == $past(ram_addr) || ram_addr == ADDR_W'($past(ram_addr) + 1'b1))); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_over && !trig) |=> sweep_over); // R5
    AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sweep_over) |-> (ram_addr == end_q)); // R5
    AST_DWELL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_over && !trig && !nodwell_q) |=> $stable(ram_addr)); // R6
    AST_PIN_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && prof_sel != $past(prof_sel)) |-> trig); // R9
endmodule

bind ramp_addr_seq rseq_checker #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .trig(trig),
    .sweep_over(sweep_over), .ram_addr(ram_addr),
    .nodwell_q(nodwell_q), .end_q(end_q)
);

// File: tb/tb_ramp_addr_seq.sv
module tb_ramp_addr_seq;
    localparam int ADDR_W = 10;
    localparam int RATE_W = 16;
    localparam int SEL_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SEL_W-1:0]  prof_sel = '0;
    logic io_update = 1'b0;
    logic wr_en = 1'b0;
    logic [SEL_W-1:0]  wr_idx = '0;
    logic [ADDR_W-1:0] wr_start = '0, wr_end = '0;
    logic [RATE_W-1:0] wr_rate = '0;
    logic wr_nodwell = 1'b0;
    logic [ADDR_W-1:0] ram_addr;
    logic sweep_over;

    always #2 clk = ~clk;

    ramp_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .io_update(io_update),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_start(wr_start), .wr_end(wr_end),
        .wr_rate(wr_rate), .wr_nodwell(wr_nodwell),
        .ram_addr(ram_addr), .sweep_over(sweep_over)
    );

    int checks = 0, errors = 0;
    int m_start [8], m_end [8], m_rate [8];
    bit m_nd [8];
    int a_start, a_end, a_rate;
    bit a_nd;
    bit started = 0, pend_trig = 0, pend_wr = 0;
    int pend_idx, pw_idx, pw_start, pw_end, pw_rate;
    bit pw_nd;
    int c = 0;
    bit done = 0;

    function automatic int exp_addr(int s0, int e0, int r, bit nd, int cyc);
        int p = (r == 0) ? 1 : r;
        int n = (e0 - s0) & ((1 << ADDR_W) - 1);
        int s = cyc / p;
        if (s < n) return (s0 + s) & ((1 << ADDR_W) - 1);
        if (nd && s >= n + 1) return s0;
        return e0;
    endfunction

    function automatic bit exp_flag(int s0, int e0, int r, int cyc);
        int p = (r == 0) ? 1 : r;
        int n = (e0 - s0) & ((1 << ADDR_W) - 1);
        int s = cyc / p;
        return s >= ((n < 1) ? 1 : n);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, c);
        end
    endtask

    // one clock: update model for the edge just passed, check, release strobes
    task automatic step(string tag);
        @(negedge clk);
        if (pend_trig) begin
            a_start = m_start[pend_idx]; a_end = m_end[pend_idx];
            a_rate = m_rate[pend_idx]; a_nd = m_nd[pend_idx];
            started = 1; c = 0;
        end else begin
            c++;
        end
        if (pend_wr) begin
            m_start[pw_idx] = pw_start; m_end[pw_idx] = pw_end;
            m_rate[pw_idx] = pw_rate; m_nd[pw_idx] = pw_nd;
        end
        pend_trig = 0; pend_wr = 0;
        if (started) begin
            check(tag, int'(ram_addr), exp_addr(a_start, a_end, a_rate, a_nd, c), "ram_addr");
            check(tag, int'(sweep_over), int'(exp_flag(a_start, a_end, a_rate, c)), "sweep_over");
        end else begin
            check(tag, int'(ram_addr), 0, "ram_addr");
            check(tag, int'(sweep_over), 0, "sweep_over");
        end
        io_update = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic write_prof(int idx, int s0, int e0, int r, bit nd);
        wr_en = 1'b1; wr_idx = SEL_W'(idx); wr_start = ADDR_W'(s0);
        wr_end = ADDR_W'(e0); wr_rate = RATE_W'(r); wr_nodwell = nd;
        pend_wr = 1; pw_idx = idx; pw_start = s0; pw_end = e0; pw_rate = r; pw_nd = nd;
    endtask

    task automatic pulse_update();
        io_update = 1'b1; pend_trig = 1; pend_idx = int'(prof_sel);
    endtask

    task automatic select(int idx);
        if (SEL_W'(idx) != prof_sel) begin
            pend_trig = 1; pend_idx = idx;
        end
        prof_sel = SEL_W'(idx);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 8; i++) begin
            m_start[i] = 0; m_end[i] = 0; m_rate[i] = 0; m_nd[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run(4, "R1");

        write_prof(1, 10, 14, 3, 0); step("R10");
        write_prof(2, 20, 23, 2, 1); step("R10");
        write_prof(3, 5, 12, 0, 0);  step("R10");
        write_prof(4, 30, 30, 4, 0); step("R10");
        write_prof(5, 100, 106, 1, 1); step("R10");
        run(2, "R1");

        select(1);    run(20, "R9");
        pulse_update(); run(20, "R6");
        select(2);    run(16, "R7");
        select(3);    run(12, "R4");
        select(4);    run(14, "R8");
        select(0); step("R2"); pulse_update(); run(3, "R2");
        select(2);    run(3, "R9");
        select(5);    run(12, "R9");
        select(1);    run(4, "R10");
        write_prof(1, 40, 42, 2, 1); run(20, "R10");
        pulse_update(); run(12, "R10");
        pulse_update(); run(2, "R3"); pulse_update(); run(10, "R3");

        for (int k = 0; k < 60; k++) begin
            int r = $urandom % 3;
            if (r == 0) begin
                write_prof($urandom % 8, $urandom % 1000, 0, 0, 0);
                pw_end = (pw_start + ($urandom % 10)) % 1024;
                pw_rate = $urandom % 5; pw_nd = 1'($urandom % 2);
                wr_end = ADDR_W'(pw_end); wr_rate = RATE_W'(pw_rate); wr_nodwell = pw_nd;
                step("R10");
            end else if (r == 1) begin
                select($urandom % 8);
            end else begin
                pulse_update();
            end
            run(1 + $urandom % 40, "R3");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule